// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit connects a 32-bit register datapath to a data memory that is organised in words. On each request it adds a sign-extended 16-bit displacement to a base register value and drives the resulting byte address to the memory. The memory returns one whole word. For a load, the unit takes either that whole word or one byte from it. A selected byte is moved to bits 7:0 of the result and the upper bits are filled with zeros or with copies of the byte's sign bit. For a store, the unit drives a write mask with one enable bit per byte lane, together with write data in which the source byte appears in every lane. A byte store therefore modifies one lane and leaves the other three bytes of the word as they were.

The `big_endian` input selects how a byte address maps to a lane, and it can change from one request to the next. A word access must fall on a 4-byte boundary. If it does not, the unit drives no write enable and flags an alignment error with the response. The load result and the error flag come back one clock cycle after the request. The address, write mask and write data reach the memory in the same cycle as the request.

Top module: `lsu_align_unit`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `offset` sign-extended to 32 bits, modulo 2^32, in the cycle of the request.
- R2: A word access whose effective address has bits 1:0 not equal to 00 drives `mem_be` = 0000. In the next cycle the unit returns `resp_err` = 1 and `resp_data` = 0. In every other case `resp_err` is 0.
- R3: The byte number is `eff_addr[1:0]`. Lane k occupies bits 8k+7:8k of the memory word. With `big_endian` = 1, byte n is in lane 3-n, so byte 0 is the most significant byte. With `big_endian` = 0, byte n is in lane n.
- R4: A byte load returns the selected byte in `resp_data[7:0]`. When `req_signed` = 0, bits 31:8 are zero.
- R5: A signed byte load (`req_signed` = 1) fills bits 31:8 with bit 7 of the selected byte.
- R6: A byte store sets exactly one bit of `mem_be`, the bit of the lane selected under R3. `mem_wdata` carries `store_data[7:0]` in all four lanes.
- R7: After a byte store, the other three bytes of the addressed memory word hold their previous values.
- R8: An aligned word load returns `mem_rdata` unchanged, whatever the value of `req_signed`. An aligned word store drives `mem_be` = 1111 and `mem_wdata` = `store_data`.
- R9: Loads and idle cycles (`req_valid` = 0) drive `mem_be` = 0000. An idle cycle produces `resp_valid` = 0 in the following cycle.
- R10: While `rst_n` is low at a clock edge, the unit clears `resp_valid`, `resp_data` and `resp_err` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| big_endian | input | 1 | 1: byte 0 is the most significant lane; 0: byte 0 is the least significant lane |
| req_valid | input | 1 | A request is present in this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_signed | input | 1 | Sign-extend a loaded byte |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register for stores |
| mem_rdata | input | 32 | Word read from memory at `eff_addr` |
| eff_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Write enable, one bit per byte lane (bit k = lane k) |
| mem_wdata | output | 32 | Lane-formatted write data |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_data | output | 32 | Load result in register format |
| resp_err | output | 1 | Misaligned word access |

## Verification
A fault in lane selection or extension shows up in `resp_data` one cycle after the load that exposes it. A fault in the write mask or write data shows up in `mem_be` and `mem_wdata` in the same cycle as the store. It also appears as corrupted neighbour bytes when the word is later read back as a whole, which is how R7 is observed at the ports. The misalignment decision is visible twice: in the mask during the request cycle and in `resp_err` one cycle later. The two must agree. Both endianness settings are applied to the same memory contents, so a lane swap cannot go unnoticed.

// File: rtl/lsu_pkg.sv
// Shared definitions for the load/store alignment unit.
// Assumes byte-sized lanes in a word whose lane count is a power of two.
package lsu_pkg;

    localparam int unsigned LSU_BYTE_W = 8;

    // Map a byte number inside a word to a lane index for a given byte order.
    function automatic int unsigned byte_to_lane(input int unsigned byte_num,
                                                 input int unsigned lanes,
                                                 input logic        msb_first);
        return msb_first ? (lanes - 1 - byte_num) : byte_num;
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
// Effective address generator.
// Adds a sign-extended displacement to a base value and reports the byte
// number and whether a word access would be misaligned. Purely combinational.
module lsu_addr_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned LANES  = 4
) (
    input  logic [ADDR_W-1:0]        base,
    input  logic [OFF_W-1:0]         disp,
    input  logic                     is_byte,
    output logic [ADDR_W-1:0]        ea,
    output logic [$clog2(LANES)-1:0] byte_num,
    output logic                     misaligned
);
    localparam int unsigned SEL_W = $clog2(LANES);

    // Sign-extend the displacement and form the byte address.
    always_comb begin
        ea         = base + {{(ADDR_W-OFF_W){disp[OFF_W-1]}}, disp};
        byte_num   = ea[SEL_W-1:0];
        misaligned = !is_byte && (ea[SEL_W-1:0] != '0);
    end
endmodule

// File: rtl/lsu_store_lane.sv
// Store-side lane formatter.
// Builds the per-lane write mask and lane-replicated write data. Assumes
// that the caller clears wr_en for loads, idle cycles and misaligned words.
module lsu_store_lane #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                               wr_en,
    input  logic                               is_byte,
    input  logic                               msb_first,
    input  logic [$clog2(DATA_W/8)-1:0]        byte_num,
    input  logic [DATA_W-1:0]                  src,
    output logic [DATA_W/8-1:0]                be,
    output logic [DATA_W-1:0]                  wdata
);
    import lsu_pkg::*;
    localparam int unsigned LANES = DATA_W / LSU_BYTE_W;
    localparam int unsigned SEL_W = $clog2(LANES);

    logic [SEL_W-1:0] tgt_lane;

    // Translate the byte number into the physical lane for this byte order.
    always_comb begin
        tgt_lane = SEL_W'(byte_to_lane(int'(byte_num), LANES, msb_first));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Enable one lane for a byte store or every lane for a word store.
        always_comb begin
            be[l] = wr_en && (!is_byte || (tgt_lane == SEL_W'(l)));
        end
        // Replicate the low source byte, or pass the word lane through.
        always_comb begin
            wdata[l*LSU_BYTE_W +: LSU_BYTE_W] = is_byte ? src[LSU_BYTE_W-1:0]
                                                        : src[l*LSU_BYTE_W +: LSU_BYTE_W];
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Load-side extractor.
// Selects one lane of the memory word and extends it to the register width,
// or passes the whole word. Purely combinational.
module lsu_load_extract #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                        is_byte,
    input  logic                        is_signed,
    input  logic                        msb_first,
    input  logic [$clog2(DATA_W/8)-1:0] byte_num,
    input  logic [DATA_W-1:0]           rdata,
    output logic [DATA_W-1:0]           result
);
    import lsu_pkg::*;
    localparam int unsigned LANES = DATA_W / LSU_BYTE_W;
    localparam int unsigned SEL_W = $clog2(LANES);

    logic [LSU_BYTE_W-1:0] lane_val [LANES];
    logic [SEL_W-1:0]      src_lane;
    logic [LSU_BYTE_W-1:0] picked;
    logic                  fill;

    for (genvar l = 0; l < LANES; l++) begin : g_split
        // Slice the memory word into lanes.
        always_comb lane_val[l] = rdata[l*LSU_BYTE_W +: LSU_BYTE_W];
    end

    // Pick the addressed lane and build the extended result.
    always_comb begin
        src_lane = SEL_W'(byte_to_lane(int'(byte_num), LANES, msb_first));
        picked   = lane_val[src_lane];
        fill     = is_signed && picked[LSU_BYTE_W-1];
        result   = is_byte ? {{(DATA_W-LSU_BYTE_W){fill}}, picked} : rdata;
    end
endmodule

// File: rtl/lsu_align_unit.sv
// Byte-lane load/store alignment unit (top).
// Drives address, write mask and write data in the request cycle and
// registers the load result and the alignment error for one cycle.
// Assumes mem_rdata is the word at eff_addr in the same cycle.
module lsu_align_unit #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OFF_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                big_endian,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic                req_byte,
    input  logic                req_signed,
    input  logic [DATA_W-1:0]   base_addr,
    input  logic [OFF_W-1:0]    offset,
    input  logic [DATA_W-1:0]   store_data,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [DATA_W-1:0]   eff_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                resp_valid,
    output logic [DATA_W-1:0]   resp_data,
    output logic                resp_err
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned SEL_W = $clog2(LANES);

    logic [SEL_W-1:0]  byte_num;
    logic              misaligned;
    logic              wr_en;
    logic [DATA_W-1:0] load_val;

    lsu_addr_gen #(.ADDR_W(DATA_W), .OFF_W(OFF_W), .LANES(LANES)) u_addr (
        .base       (base_addr),
        .disp       (offset),
        .is_byte    (req_byte),
        .ea         (eff_addr),
        .byte_num   (byte_num),
        .misaligned (misaligned)
    );

    // Only an aligned store request may write memory.
    always_comb wr_en = req_valid && req_store && !misaligned;

    lsu_store_lane #(.DATA_W(DATA_W)) u_store (
        .wr_en     (wr_en),
        .is_byte   (req_byte),
        .msb_first (big_endian),
        .byte_num  (byte_num),
        .src       (store_data),
        .be        (mem_be),
        .wdata     (mem_wdata)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .is_byte   (req_byte),
        .is_signed (req_signed),
        .msb_first (big_endian),
        .byte_num  (byte_num),
        .rdata     (mem_rdata),
        .result    (load_val)
    );

    // Register the response: load value, or zero with the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
            resp_err   <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_err   <= req_valid && misaligned;
            resp_data  <= (req_valid && !req_store && !misaligned) ? load_val : '0;
        end
    end

    AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_byte && (eff_addr[1:0] != 2'b00)) |-> (mem_be == '0)); // R2
    AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_byte && (eff_addr[1:0] != 2'b00)) |=> resp_err); // R2
    AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_byte) |-> ($countones(mem_be) == 1)); // R6
    AST_UNSIGNED_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_byte && !req_signed) |=> (resp_data[DATA_W-1:8] == '0)); // R4
    AST_NO_WRITE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_store) |-> (mem_be == '0)); // R9
    AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R9
endmodule

// File: tb/tb_lsu_align_unit.sv
module tb_lsu_align_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b1;
    logic        req_valid = 1'b0, req_store = 1'b0, req_byte = 1'b0, req_signed = 1'b0;
    logic [31:0] base_addr = '0, store_data = '0;
    logic [15:0] offset = '0;
    logic [31:0] mem_rdata, eff_addr, mem_wdata, resp_data;
    logic [3:0]  mem_be;
    logic        resp_valid, resp_err;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct { logic [31:0] data; logic err; string tag; } exp_t;
    exp_t sb[$];

    logic [31:0] mem [16];

    always #5 clk = ~clk;

    lsu_align_unit dut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_valid(req_valid),
        .req_store(req_store), .req_byte(req_byte), .req_signed(req_signed),
        .base_addr(base_addr), .offset(offset), .store_data(store_data),
        .mem_rdata(mem_rdata), .eff_addr(eff_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_err(resp_err)
    );

    // Memory model: combinational read, per-lane write on the clock edge.
    assign mem_rdata = mem[eff_addr[5:2]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
            mem[0] <= 32'h009012A0;
            mem[1] <= 32'hFFFFFFFF;
        end else begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[eff_addr[5:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected response", resp_data, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(resp_data == e.data, e.tag, resp_data, e.data);
                check(resp_err == e.err, {e.tag, " err"}, 32'(resp_err), 32'(e.err));
            end
        end
    end

    // Driver: apply one request at a falling edge and queue its expected response.
    task automatic drive(input bit st, input bit by, input bit sg, input bit be_big,
                         input logic [31:0] b, input logic [15:0] off, input logic [31:0] sd,
                         input logic [31:0] exp_d, input bit exp_e, input string tag);
        exp_t e;
        req_valid = 1'b1; req_store = st; req_byte = by; req_signed = sg;
        big_endian = be_big; base_addr = b; offset = off; store_data = sd;
        e.data = exp_d; e.err = exp_e; e.tag = tag;
        sb.push_back(e);
        #1;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(resp_valid == 1'b0, "R10 resp_valid in reset", 32'(resp_valid), 32'h0);
        check(resp_data == 32'h0, "R10 resp_data in reset", resp_data, 32'h0);
        check(resp_err == 1'b0, "R10 resp_err in reset", 32'(resp_err), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: unsigned byte loads from word 0 at address 1, both orders
        drive(0,1,0,1, 32'h0, 16'h0001, 32'h0, 32'h00000090, 0, "R3 R4 big-endian byte 1");
        finish_cycle();
        drive(0,1,0,0, 32'h0, 16'h0001, 32'h0, 32'h00000012, 0, "R3 R4 little-endian byte 1");
        finish_cycle();
        // R5: signed byte loads
        drive(0,1,1,1, 32'h0, 16'h0003, 32'h0, 32'hFFFFFFA0, 0, "R5 signed big-endian byte 3");
        finish_cycle();
        drive(0,1,0,1, 32'h0, 16'h0003, 32'h0, 32'h000000A0, 0, "R4 unsigned big-endian byte 3");
        finish_cycle();
        drive(0,1,1,0, 32'h0, 16'h0000, 32'h0, 32'hFFFFFFA0, 0, "R5 signed little-endian byte 0");
        finish_cycle();
        drive(0,1,1,0, 32'h0, 16'h0003, 32'h0, 32'h00000000, 0, "R5 signed positive byte");
        finish_cycle();

        // R1 R8: negative displacement, aligned word load with signed flag ignored
        drive(0,0,1,1, 32'h10, 16'hFFF0, 32'h0, 32'h009012A0, 0, "R8 word load");
        check(eff_addr == 32'h0, "R1 negative offset", eff_addr, 32'h0);
        check(mem_be == 4'h0, "R9 load writes nothing", 32'(mem_be), 32'h0);
        finish_cycle();
        drive(0,1,0,1, 32'h1000, 16'h8000, 32'h0, 32'h00000000, 0, "R1 far byte load");
        check(eff_addr == 32'hFFFF9000, "R1 sign extension", eff_addr, 32'hFFFF9000);
        finish_cycle();

        // R6 R7: big-endian byte store at address 6 (base 8, offset -2)
        drive(1,1,0,1, 32'h8, 16'hFFFE, 32'h12345690, 32'h0, 0, "R6 big-endian store resp");
        check(mem_be == 4'b0010, "R6 big-endian lane mask", 32'(mem_be), 32'h2);
        check(mem_wdata == 32'h90909090, "R6 replicated data", mem_wdata, 32'h90909090);
        finish_cycle();
        drive(0,0,0,1, 32'h4, 16'h0000, 32'h0, 32'hFFFF90FF, 0, "R7 big-endian neighbours kept");
        finish_cycle();

        // R8: aligned word store restores word 1
        drive(1,0,0,1, 32'h4, 16'h0000, 32'hFFFFFFFF, 32'h0, 0, "R8 word store resp");
        check(mem_be == 4'hF, "R8 word store mask", 32'(mem_be), 32'hF);
        check(mem_wdata == 32'hFFFFFFFF, "R8 word store data", mem_wdata, 32'hFFFFFFFF);
        finish_cycle();
        // R6 R7: little-endian byte store at address 6
        drive(1,1,0,0, 32'h6, 16'h0000, 32'hABCDEF12, 32'h0, 0, "R6 little-endian store resp");
        check(mem_be == 4'b0100, "R6 little-endian lane mask", 32'(mem_be), 32'h4);
        check(mem_wdata == 32'h12121212, "R6 little-endian data", mem_wdata, 32'h12121212);
        finish_cycle();
        drive(0,0,0,0, 32'h4, 16'h0000, 32'h0, 32'hFF12FFFF, 0, "R7 little-endian neighbours kept");
        finish_cycle();

        // R2: misaligned word load and store
        drive(0,0,0,1, 32'h0, 16'h0002, 32'h0, 32'h0, 1, "R2 misaligned load");
        finish_cycle();
        drive(1,0,0,1, 32'h4, 16'h0001, 32'h00000000, 32'h0, 1, "R2 misaligned store");
        check(mem_be == 4'h0, "R2 misaligned store mask", 32'(mem_be), 32'h0);
        finish_cycle();
        drive(0,0,0,1, 32'h4, 16'h0000, 32'h0, 32'hFF12FFFF, 0, "R2 word untouched");
        finish_cycle();

        // R9: idle cycle
        req_valid = 1'b0; req_store = 1'b1; req_byte = 1'b1;
        #1;
        check(mem_be == 4'h0, "R9 idle mask", 32'(mem_be), 32'h0);
        @(negedge clk);
        #1;
        check(resp_valid == 1'b0, "R9 idle no response", 32'(resp_valid), 32'h0);
        @(negedge clk);
        @(negedge clk);
        check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule